// File: doc/BRIEF.md
# Stepper Driver Fault Supervisor

This block watches the fault comparators of a two-coil stepper driver and turns them into status flags that software reads over a serial link. Thermal warning and charge-pump failure track their comparators. Thermal shutdown, the eight per-transistor over-current indications and the two open-coil detections are latched. A latched flag stays set until software reads the status register that holds it. The block decides, from the type of fault present, whether both coils, one coil or neither coil may drive. It also produces an active-low error pin that is the combined fault indication.

Open-coil detection watches each coil's full-duty indication from its current regulator. When that indication has persisted for more than a programmable number of millisecond ticks, the block latches an open-coil flag. A clear pin returns all state to its reset values. A sleep input tristates both coils, keeps every flag, and blocks step and direction commands. After the sleep input falls, step commands stay blocked for a programmable settling window.

Top module: `motor_fault_supervisor`

## Requirements
- R1: `stat0_o[0]` (thermal warning) equals `temp_warn_i` as sampled at the previous clock edge.
- R2: A high `temp_shut_i` latches the shutdown flag `stat2_o[7]` at the next edge. While that flag is set, `drv_en_o` is 2'b00.
- R3: The shutdown flag clears only on an edge where `rd_stat2_i` is high, `temp_warn_i` is low and `temp_shut_i` is low. A read while the warning input is high leaves the flag set.
- R4: Each high bit of `ovc_x_i`/`ovc_y_i` latches the matching bit of `stat1_o[3:0]` (X coil) or `stat2_o[3:0]` (Y coil). While any of these bits is set, `drv_en_o` is 2'b00.
- R5: A coil's full-duty input (`full_duty_i[0]` for X, `[1]` for Y) that stays high for OPEN_TICKS+1 consecutive ticks sets that coil's open flag (`stat0_o[2]` for X, `stat0_o[3]` for Y). The open flag clears only that coil's bit of `drv_en_o` (bit 0 is X, bit 1 is Y). A low full-duty input restarts the count.
- R6: `stat0_o[1]` (charge-pump fail) follows `cp_low_i` with one edge of delay and reads 1 out of reset.
- R7: `err_n_o` is low exactly when any of these is set: thermal warning, shutdown, an over-current bit, an open-coil bit or charge-pump fail.
- R8: A read strobe clears only the latched bits of its own register: `rd_stat0_i` clears the open flags, `rd_stat1_i` the X over-current bits, `rd_stat2_i` the Y over-current bits and the shutdown flag. A fault present on the same edge keeps its bit set.
- R9: While `clear_i` is high, all flags take their reset values at each edge and `drv_en_o` is 2'b00. Normal operation resumes once `clear_i` is low.
- R10: While `sleep_i` is high, `drv_en_o` is 2'b00, `step_o` is low, `dir_o` holds its value and the latched flags are kept. Reads still clear flags.
- R11: After `sleep_i` falls, `step_o` stays low through WAKE_CYCLES further edges and follows `step_i` after that. `dir_o` samples `dir_i` only while steps are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous hard clear, active high |
| tick_ms_i | input | 1 | One-cycle pulse per millisecond |
| temp_warn_i | input | 1 | Warning-temperature comparator |
| temp_shut_i | input | 1 | Shutdown-temperature comparator |
| ovc_x_i | input | 4 | Over-current comparators, X coil transistors |
| ovc_y_i | input | 4 | Over-current comparators, Y coil transistors |
| full_duty_i | input | 2 | Regulator at full duty, bit 0 X, bit 1 Y |
| cp_low_i | input | 1 | Charge-pump voltage below threshold |
| rd_stat0_i | input | 1 | Read strobe, status register 0 |
| rd_stat1_i | input | 1 | Read strobe, status register 1 |
| rd_stat2_i | input | 1 | Read strobe, status register 2 |
| sleep_i | input | 1 | Sleep request |
| step_i | input | 1 | Step command in |
| dir_i | input | 1 | Direction in |
| stat0_o | output | 8 | {4'b0, open Y, open X, cp fail, warning} |
| stat1_o | output | 8 | {4'b0, X over-current bits} |
| stat2_o | output | 8 | {shutdown, 3'b0, Y over-current bits} |
| drv_en_o | output | 2 | Coil output stage enable, 0 means high impedance |
| step_o | output | 1 | Gated step command |
| dir_o | output | 1 | Held direction |
| err_n_o | output | 1 | Combined fault indication, active low |

## Verification
Every flag is a register, so a fault or read strobe applied before an edge shows in the status outputs right after that edge. The driver enables and the error pin decode those registers without added delay, so they are due in the same cycle. The open flag is due on the edge that carries the OPEN_TICKS+1-th tick, and a step command becomes visible WAKE_CYCLES+1 edges after sleep falls. The bench drives on falling edges and counts exactly that many falling edges before sampling, so each check lands on the first cycle in which its result is due. It also samples one cycle earlier to confirm the result is not yet present.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
    localparam int NUM_COILS     = 2;
    localparam int FETS_PER_COIL = 4;

    typedef struct packed {
        logic                     tw;
        logic                     tsd;
        logic                     cpfail;
        logic [NUM_COILS-1:0]     open;
        logic [FETS_PER_COIL-1:0] ovc_x;
        logic [FETS_PER_COIL-1:0] ovc_y;
    } flags_t;

    localparam flags_t FLAGS_RST = '{
        tw:     1'b0,
        tsd:    1'b0,
        cpfail: 1'b1,
        open:   '0,
        ovc_x:  '0,
        ovc_y:  '0
    };
endpackage

// File: rtl/mfs_open_timer.sv
module mfs_open_timer #(
    parameter int OPEN_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    input  logic full_i,
    output logic expire_o
);
    localparam int CW = $clog2(OPEN_TICKS + 1);
    localparam logic [CW-1:0] LIM = CW'(OPEN_TICKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d    = tmr_q;
        expire_o = full_i && tick_i && (tmr_q.cnt == LIM);
        if (clear_i || !full_i) begin
            tmr_d.cnt = '0;
        end else if (tick_i && (tmr_q.cnt != LIM)) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R5: a break in full duty restarts the persistence count
    assert_restart_on_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !full_i |=> (tmr_q.cnt == '0));

    // R5: the count never passes its limit
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LIM);
endmodule

// File: rtl/mfs_wake_gate.sv
module mfs_wake_gate #(
    parameter int WAKE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic sleep_i,
    input  logic step_i,
    input  logic dir_i,
    output logic step_o,
    output logic dir_o
);
    localparam int CW = $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] WAKE = CW'(WAKE_CYCLES);

    typedef struct packed {
        logic          slp;
        logic [CW-1:0] cnt;
        logic          dir;
    } wake_t;

    wake_t wk_d, wk_q;
    logic  blocked;

    always_comb begin
        blocked = sleep_i || wk_q.slp || (wk_q.cnt != '0);
        wk_d    = wk_q;
        if (clear_i) begin
            wk_d = '0;
        end else begin
            wk_d.slp = sleep_i;
            if (wk_q.slp && !sleep_i)  wk_d.cnt = WAKE;
            else if (wk_q.cnt != '0)   wk_d.cnt = wk_q.cnt - 1'b1;
            if (!blocked)              wk_d.dir = dir_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wk_q <= '0;
        else        wk_q <= wk_d;
    end

    assign step_o = step_i && !blocked;
    assign dir_o  = wk_q.dir;

    // R11: leaving sleep arms the full settling window
    assert_wake_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_q.slp && !sleep_i && !clear_i) |=> (wk_q.cnt == WAKE));

    // R10: no step passes while sleep is requested
    assert_sleep_no_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |-> !step_o);

    // R10: direction is held while sleeping
    assert_dir_held_R10: assert property (@(posedge clk) disable iff (!rst_n || clear_i)
        (sleep_i && $past(sleep_i)) |-> $stable(dir_o));
endmodule

// File: rtl/motor_fault_supervisor.sv
module motor_fault_supervisor
    import mfs_pkg::*;
#(
    parameter int OPEN_TICKS  = 200,
    parameter int WAKE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       tick_ms_i,
    input  logic       temp_warn_i,
    input  logic       temp_shut_i,
    input  logic [3:0] ovc_x_i,
    input  logic [3:0] ovc_y_i,
    input  logic [1:0] full_duty_i,
    input  logic       cp_low_i,
    input  logic       rd_stat0_i,
    input  logic       rd_stat1_i,
    input  logic       rd_stat2_i,
    input  logic       sleep_i,
    input  logic       step_i,
    input  logic       dir_i,
    output logic [7:0] stat0_o,
    output logic [7:0] stat1_o,
    output logic [7:0] stat2_o,
    output logic [1:0] drv_en_o,
    output logic       step_o,
    output logic       dir_o,
    output logic       err_n_o
);
    flags_t               fl_d, fl_q;
    logic [NUM_COILS-1:0] expire;
    logic                 tick_run;
    logic                 hiz_all;

    assign tick_run = tick_ms_i && !sleep_i;

    for (genvar c = 0; c < NUM_COILS; c++) begin : g_coil
        mfs_open_timer #(.OPEN_TICKS(OPEN_TICKS)) i_open_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear_i  (clear_i),
            .tick_i   (tick_run),
            .full_i   (full_duty_i[c]),
            .expire_o (expire[c])
        );
        assign drv_en_o[c] = !hiz_all && !fl_q.open[c];
    end

    mfs_wake_gate #(.WAKE_CYCLES(WAKE_CYCLES)) i_wake_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .sleep_i (sleep_i),
        .step_i  (step_i),
        .dir_i   (dir_i),
        .step_o  (step_o),
        .dir_o   (dir_o)
    );

    always_comb begin
        fl_d = fl_q;
        if (clear_i) begin
            fl_d = FLAGS_RST;
        end else begin
            fl_d.tw     = temp_warn_i;
            fl_d.cpfail = cp_low_i;
            if (rd_stat2_i && !temp_warn_i) fl_d.tsd = 1'b0;
            if (temp_shut_i)                fl_d.tsd = 1'b1;
            if (rd_stat1_i) fl_d.ovc_x = '0;
            if (rd_stat2_i) fl_d.ovc_y = '0;
            if (rd_stat0_i) fl_d.open  = '0;
            fl_d.ovc_x = fl_d.ovc_x | ovc_x_i;
            fl_d.ovc_y = fl_d.ovc_y | ovc_y_i;
            fl_d.open  = fl_d.open  | expire;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= FLAGS_RST;
        else        fl_q <= fl_d;
    end

    assign hiz_all = clear_i || sleep_i || fl_q.tsd || (|fl_q.ovc_x) || (|fl_q.ovc_y);
    assign err_n_o = !(fl_q.tw || fl_q.tsd || fl_q.cpfail || (|fl_q.open)
                       || (|fl_q.ovc_x) || (|fl_q.ovc_y));
    assign stat0_o = {4'b0000, fl_q.open[1], fl_q.open[0], fl_q.cpfail, fl_q.tw};
    assign stat1_o = {4'b0000, fl_q.ovc_x};
    assign stat2_o = {fl_q.tsd, 3'b000, fl_q.ovc_y};

    // R1: the warning bit tracks its comparator
    assert_tw_follow_R1: assert property (@(posedge clk) disable iff (!rst_n || clear_i)
        temp_warn_i |=> stat0_o[0]);

    // R2: shutdown input latches the flag and tristates both coils
    assert_tsd_latch_R2: assert property (@(posedge clk) disable iff (!rst_n || clear_i)
        temp_shut_i |=> (stat2_o[7] && (drv_en_o == 2'b00)));

    // R3: shutdown only releases on a qualified read or a clear
    assert_tsd_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_q.tsd) |-> ($past(clear_i)
            || $past(rd_stat2_i && !temp_warn_i && !temp_shut_i)));

    // R4: any latched over-current bit keeps both coils off
    assert_ovc_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|stat1_o[3:0]) || (|stat2_o[3:0])) |-> (drv_en_o == 2'b00));

    // R5: an open flag only rises after full duty was seen
    assert_open_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat0_o[2]) |-> $past(full_duty_i[0]));

    // R7: shutdown always pulls the error pin low
    assert_err_on_tsd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stat2_o[7] |-> !err_n_o);

    // R9: clear forces the reset contents on the next edge
    assert_clear_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (stat1_o == 8'h00 && stat2_o == 8'h00 && stat0_o == 8'h02));
endmodule

// File: tb/test_motor_fault_supervisor.sv
module test_motor_fault_supervisor;
    localparam int OPEN_TICKS  = 200;
    localparam int WAKE_CYCLES = 16;
    localparam int NVEC        = 17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear_i = 1'b0, tick_ms_i = 1'b0;
    logic       temp_warn_i = 1'b0, temp_shut_i = 1'b0;
    logic [3:0] ovc_x_i = '0, ovc_y_i = '0;
    logic [1:0] full_duty_i = '0;
    logic       cp_low_i = 1'b1;
    logic       rd_stat0_i = 1'b0, rd_stat1_i = 1'b0, rd_stat2_i = 1'b0;
    logic       sleep_i = 1'b0, step_i = 1'b0, dir_i = 1'b0;
    logic [7:0] stat0_o, stat1_o, stat2_o;
    logic [1:0] drv_en_o;
    logic       step_o, dir_o, err_n_o;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    motor_fault_supervisor #(.OPEN_TICKS(OPEN_TICKS), .WAKE_CYCLES(WAKE_CYCLES))
        i_motor_fault_supervisor (.*);

    // {warn, shut, ovc_x, ovc_y, cp_low, rd0, rd1, rd2, exp stat0, stat1, stat2, drv_en, err_n}
    localparam logic [40:0] VEC [NVEC] = '{
        {1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,2'b11,1'b1}, // R6 pump ready
        {1'b1,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,1'b0, 8'h01,8'h00,8'h00,2'b11,1'b0}, // R1 R7
        {1'b1,1'b1,4'h0,4'h0,1'b0,1'b0,1'b0,1'b0, 8'h01,8'h00,8'h80,2'b00,1'b0}, // R2
        {1'b1,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,1'b1, 8'h01,8'h00,8'h80,2'b00,1'b0}, // R3 warm read
        {1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h80,2'b00,1'b0}, // R3 no read
        {1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,1'b1, 8'h00,8'h00,8'h00,2'b11,1'b1}, // R3 release
        {1'b0,1'b0,4'h4,4'h0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h04,8'h00,2'b00,1'b0}, // R4 X
        {1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,1'b1, 8'h00,8'h04,8'h00,2'b00,1'b0}, // R8 other reg
        {1'b0,1'b0,4'h0,4'h8,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h04,8'h08,2'b00,1'b0}, // R4 Y
        {1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b1,1'b0, 8'h00,8'h00,8'h08,2'b00,1'b0}, // R8 read 1
        {1'b0,1'b0,4'h0,4'h8,1'b0,1'b0,1'b0,1'b1, 8'h00,8'h00,8'h08,2'b00,1'b0}, // R8 set wins
        {1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,1'b1, 8'h00,8'h00,8'h00,2'b11,1'b1}, // R8 read 2
        {1'b0,1'b0,4'h0,4'h0,1'b1,1'b0,1'b0,1'b0, 8'h02,8'h00,8'h00,2'b11,1'b0}, // R6 R7
        {1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h00,2'b11,1'b1}, // R6
        {1'b0,1'b1,4'h0,4'h0,1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,8'h80,2'b00,1'b0}, // R2 cool
        {1'b0,1'b1,4'h0,4'h0,1'b0,1'b0,1'b0,1'b1, 8'h00,8'h00,8'h80,2'b00,1'b0}, // R3 set wins
        {1'b0,1'b0,4'h0,4'h0,1'b0,1'b0,1'b0,1'b1, 8'h00,8'h00,8'h00,2'b11,1'b1}  // R3 release
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        tests++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // R6 R7 reset state
        chk("R6 reset stat0", stat0_o, 8'h02);
        chk("R6 reset stat1/2", {stat1_o, stat2_o}, 16'h0000);
        chk("R7 reset err_n", err_n_o, 1'b0);
        chk("R2 reset drv_en", drv_en_o, 2'b11);

        for (int i = 0; i < NVEC; i++) begin
            logic [40:0] v;
            v = VEC[i];
            temp_warn_i = v[40]; temp_shut_i = v[39];
            ovc_x_i = v[38:35];  ovc_y_i = v[34:31];
            cp_low_i = v[30];
            rd_stat0_i = v[29]; rd_stat1_i = v[28]; rd_stat2_i = v[27];
            wait_n(1);
            chk($sformatf("vec%0d stat0 R1/R6", i), stat0_o, v[26:19]);
            chk($sformatf("vec%0d stat1 R4/R8", i), stat1_o, v[18:11]);
            chk($sformatf("vec%0d stat2 R2/R3", i), stat2_o, v[10:3]);
            chk($sformatf("vec%0d drv_en R2/R4", i), drv_en_o, v[2:1]);
            chk($sformatf("vec%0d err_n R7", i), err_n_o, v[0]);
        end
        temp_shut_i = 1'b0; rd_stat2_i = 1'b0;

        // R5 open coil on X
        tick_ms_i = 1'b1;
        full_duty_i = 2'b01;
        wait_n(OPEN_TICKS);
        chk("R5 X not yet open", stat0_o, 8'h00);
        wait_n(1);
        chk("R5 X open", stat0_o, 8'h04);
        chk("R5 only X off", drv_en_o, 2'b10);
        chk("R7 open err", err_n_o, 1'b0);
        full_duty_i = 2'b00; rd_stat0_i = 1'b1;
        wait_n(1);
        chk("R8 read0 clears open", stat0_o, 8'h00);
        chk("R5 X back on", drv_en_o, 2'b11);
        rd_stat0_i = 1'b0;

        // R5 restart on Y
        full_duty_i = 2'b10;
        wait_n(150);
        full_duty_i = 2'b00;
        wait_n(1);
        full_duty_i = 2'b10;
        wait_n(OPEN_TICKS);
        chk("R5 Y restarted", stat0_o, 8'h00);
        wait_n(1);
        chk("R5 Y open", stat0_o, 8'h08);
        chk("R5 only Y off", drv_en_o, 2'b01);
        full_duty_i = 2'b00; rd_stat0_i = 1'b1;
        wait_n(1);
        rd_stat0_i = 1'b0;
        tick_ms_i = 1'b0;
        chk("R8 Y cleared", stat0_o, 8'h00);

        // R9 clear pin
        ovc_x_i = 4'h1; temp_shut_i = 1'b1;
        wait_n(1);
        ovc_x_i = 4'h0; temp_shut_i = 1'b0; clear_i = 1'b1;
        wait_n(1);
        chk("R9 clear stat0", stat0_o, 8'h02);
        chk("R9 clear stat1/2", {stat1_o, stat2_o}, 16'h0000);
        chk("R9 clear drv off", drv_en_o, 2'b00);
        clear_i = 1'b0;
        wait_n(1);
        chk("R9 resume drv", drv_en_o, 2'b11);
        chk("R9 resume err", err_n_o, 1'b1);

        // R10 sleep
        ovc_y_i = 4'h1;
        wait_n(1);
        ovc_y_i = 4'h0; sleep_i = 1'b1; step_i = 1'b1; dir_i = 1'b1;
        wait_n(1);
        chk("R10 sleep drv off", drv_en_o, 2'b00);
        chk("R10 sleep step blocked", step_o, 1'b0);
        chk("R10 sleep dir held", dir_o, 1'b0);
        chk("R10 flag kept", stat2_o, 8'h01);
        rd_stat2_i = 1'b1;
        wait_n(1);
        rd_stat2_i = 1'b0;
        chk("R10 read in sleep", stat2_o, 8'h00);

        // R11 wake window
        sleep_i = 1'b0;
        wait_n(WAKE_CYCLES);
        chk("R11 still blocked", step_o, 1'b0);
        chk("R11 dir still held", dir_o, 1'b0);
        chk("R10 drv back", drv_en_o, 2'b11);
        wait_n(1);
        chk("R11 step passes", step_o, 1'b1);
        wait_n(1);
        chk("R11 dir follows", dir_o, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule